// File: doc/BRIEF.md
# Keyed-Lock GPIO Pad Mode Controller

This block holds the output state of a bank of up to 32 general-purpose pins behind a 32-bit register interface. For every pin it keeps one data-out bit and two drive-mode bits. Together they pick one of four pad behaviours: high-impedance input, push-pull output, open-drain (drives low only) or open-source (drives high only). Pad inputs pass through a two-flop synchronizer into a data-in register that software can read.

Software changes data-out through separate set and clear registers, so no read-modify-write is needed. Mode bits can also be set or cleared bit by bit. The whole mode0 and mode1 registers can be read and rewritten, which lets software save and restore them. No mode bit can change unless a lock register has first been armed with a 16-bit key. Writing zero to the lock disarms it.

Top module: `keyed_gpio_ctrl`

## Requirements
- R1: After a synchronous reset, data-out, mode0, mode1 and the lock are all 0. Every pin is therefore an input, `pad_oe` is all 0 and every mapped register reads 0.
- R2: A write to data-set (0x14) sets only the data-out bits written as 1, and a write to data-clear (0x18) clears only the bits written as 1. All other bits keep their value. Reading either offset returns data-out.
- R3: The pad drive for {mode1,mode0} and data-out d works as follows. 00 floats. 01 drives d. 10 drives 0 when d=0 and floats when d=1. 11 floats when d=0 and drives 1 when d=1. A floating pin has `pad_oe`=0 and `pad_out`=0.
- R4: A lock write (offset 0x88) whose bits [15:0] are 0xD42F arms the lock, and one whose bits are 0x0000 disarms it. Any other key leaves the lock state as it was. Lock readback bit 31 is 1 exactly while the lock is armed, and all other bits read 0.
- R5: While the lock is disarmed, writes to mode0, mode1 and their set and clear offsets change nothing.
- R6: While the lock is armed, the mode registers can be changed in three ways. Mode0-set (0x54) and mode1-set (0x4C) set the bits written as 1. Mode0-clear (0x58) and mode1-clear (0x50) clear the bits written as 1. Writing mode0 (0x0C) or mode1 (0x08) loads the whole register. Both mode registers read back at 0x0C and 0x08.
- R7: A change on `pad_in` that is sampled at one rising edge appears in the data-in readback (0x04) after the third rising edge, not before.
- R8: Bits at and above NUM_PINS read as 0 in every register, and writes to those bits are dropped.
- R9: A read of any offset that is not mapped returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte offset for the read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Level driven toward each pad |
| pad_oe | output | NUM_PINS | Output enable for each pad |

## Verification
The bench runs the design with 24 populated pins, so that the unpopulated upper byte is exercised. Each mode is tried with alternating and all-ones/all-zeros data-out patterns, which separates the four pad encodings from one another. Mode writes are attempted before the lock is armed, with a wrong key, while armed, and after the lock is disarmed; this shows the key gate is the only path to the mode bits. A pad step is timed edge by edge to tell a synchronizer that is too short or too long from the correct three-edge latency.

// File: rtl/kgc_pkg.sv
package kgc_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned OFS_W     = 12;
    localparam int unsigned KEY_W     = 16;
    localparam int unsigned FLAG_BIT  = 31;
    localparam int unsigned MAX_PINS  = 32;

    localparam logic [KEY_W-1:0] KEY_ARM    = 16'hD42F;
    localparam logic [KEY_W-1:0] KEY_DISARM = 16'h0000;

    localparam logic [OFS_W-1:0] OFS_DIN    = 12'h004;
    localparam logic [OFS_W-1:0] OFS_MODE1  = 12'h008;
    localparam logic [OFS_W-1:0] OFS_MODE0  = 12'h00C;
    localparam logic [OFS_W-1:0] OFS_DSET   = 12'h014;
    localparam logic [OFS_W-1:0] OFS_DCLR   = 12'h018;
    localparam logic [OFS_W-1:0] OFS_M1SET  = 12'h04C;
    localparam logic [OFS_W-1:0] OFS_M1CLR  = 12'h050;
    localparam logic [OFS_W-1:0] OFS_M0SET  = 12'h054;
    localparam logic [OFS_W-1:0] OFS_M0CLR  = 12'h058;
    localparam logic [OFS_W-1:0] OFS_LOCK   = 12'h088;

    typedef enum logic [1:0] {
        PM_FLOAT     = 2'b00,
        PM_PUSHPULL  = 2'b01,
        PM_SINK_ONLY = 2'b10,
        PM_SRC_ONLY  = 2'b11
    } pad_mode_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pad_drv_t;

    typedef struct packed {
        logic dat_set;
        logic dat_clr;
        logic m0_set;
        logic m0_clr;
        logic m1_set;
        logic m1_clr;
        logic m0_load;
        logic m1_load;
        logic lock_wr;
    } wr_sel_t;

    function automatic pad_drv_t pad_drive(pad_mode_e mode, logic dat);
        pad_drv_t r;
        r = '0;
        unique case (mode)
            PM_FLOAT:     r = '0;
            PM_PUSHPULL:  begin r.oe = 1'b1; r.val = dat; end
            PM_SINK_ONLY: begin r.oe = ~dat; r.val = 1'b0; end
            PM_SRC_ONLY:  begin r.oe = dat;  r.val = dat;  end
            default:      r = '0;
        endcase
        return r;
    endfunction

    function automatic wr_sel_t decode_write(logic wr, logic [OFS_W-1:0] ofs);
        wr_sel_t s;
        s = '0;
        if (wr) begin
            unique case (ofs)
                OFS_DSET:  s.dat_set = 1'b1;
                OFS_DCLR:  s.dat_clr = 1'b1;
                OFS_M0SET: s.m0_set  = 1'b1;
                OFS_M0CLR: s.m0_clr  = 1'b1;
                OFS_M1SET: s.m1_set  = 1'b1;
                OFS_M1CLR: s.m1_clr  = 1'b1;
                OFS_MODE0: s.m0_load = 1'b1;
                OFS_MODE1: s.m1_load = 1'b1;
                OFS_LOCK:  s.lock_wr = 1'b1;
                default:   s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/kgc_sync.sv
module kgc_sync #(
    parameter int unsigned WIDTH       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] din_q
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [WIDTH-1:0] stg [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= pad_in;
    end

    for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= '0;
            else     stg[k] <= stg[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) din_q <= '0;
        else     din_q <= stg[LAST];
    end

    // Counts edges since reset so the latency check never looks before it.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    if (SYNC_STAGES == 2) begin : g_lat_chk
        p_din_latency_r7: assert property (@(posedge clk) disable iff (rst)
            (since_rst == 2'd3) |-> (din_q == $past(pad_in, 3)));
    end

endmodule

// File: rtl/kgc_lock.sv
module kgc_lock
    import kgc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_wr,
    input  logic [KEY_W-1:0] key,
    output logic             armed
);
    typedef enum logic [1:0] { KA_NONE, KA_ARM, KA_DISARM } key_act_e;
    key_act_e act;

    always_comb begin
        act = KA_NONE;
        if (lock_wr) begin
            if (key == KEY_ARM)         act = KA_ARM;
            else if (key == KEY_DISARM) act = KA_DISARM;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else begin
            unique case (act)
                KA_ARM:    armed <= 1'b1;
                KA_DISARM: armed <= 1'b0;
                default:   armed <= armed;
            endcase
        end
    end

    p_arm_key_r4: assert property (@(posedge clk) disable iff (rst)
        (lock_wr && key == KEY_ARM) |=> armed);
    p_disarm_key_r4: assert property (@(posedge clk) disable iff (rst)
        (lock_wr && key == KEY_DISARM) |=> !armed);
    p_other_key_r4: assert property (@(posedge clk) disable iff (rst)
        (lock_wr && key != KEY_ARM && key != KEY_DISARM) |=> $stable(armed));
    p_no_write_r4: assert property (@(posedge clk) disable iff (rst)
        !lock_wr |=> $stable(armed));

endmodule

// File: rtl/kgc_regs.sv
module kgc_regs
    import kgc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_sel_t          sel,
    input  logic [WIDTH-1:0] wdata,
    input  logic             armed,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] mode0,
    output logic [WIDTH-1:0] mode1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            mode0 <= '0;
            mode1 <= '0;
        end else begin
            if (sel.dat_set) dout <= dout | wdata;
            if (sel.dat_clr) dout <= dout & ~wdata;
            if (armed) begin
                if (sel.m0_set)  mode0 <= mode0 | wdata;
                if (sel.m0_clr)  mode0 <= mode0 & ~wdata;
                if (sel.m0_load) mode0 <= wdata;
                if (sel.m1_set)  mode1 <= mode1 | wdata;
                if (sel.m1_clr)  mode1 <= mode1 & ~wdata;
                if (sel.m1_load) mode1 <= wdata;
            end
        end
    end

    p_mode_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !armed |=> ($stable(mode0) && $stable(mode1)));
    p_dset_hits_r2: assert property (@(posedge clk) disable iff (rst)
        sel.dat_set |=> ((dout & $past(wdata)) == $past(wdata)));
    p_dset_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        sel.dat_set |=> ((dout & ~$past(wdata)) == ($past(dout) & ~$past(wdata))));
    p_dclr_hits_r2: assert property (@(posedge clk) disable iff (rst)
        sel.dat_clr |=> ((dout & $past(wdata)) == '0));
    p_m0set_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && sel.m0_set) |=> ((mode0 & $past(wdata)) == $past(wdata)));
    p_m1clr_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && sel.m1_clr) |=> ((mode1 & $past(wdata)) == '0));

endmodule

// File: rtl/kgc_pad.sv
module kgc_pad
    import kgc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] dout,
    input  logic [WIDTH-1:0] mode0,
    input  logic [WIDTH-1:0] mode1,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pad_drv_t drv;
        always_comb drv = pad_drive(pad_mode_e'({mode1[i], mode0[i]}), dout[i]);
        assign pad_out[i] = drv.val;
        assign pad_oe[i]  = drv.oe;

        p_input_floats_r3: assert property (@(posedge clk) disable iff (rst)
            (!mode1[i] && !mode0[i]) |-> (!pad_oe[i] && !pad_out[i]));
        p_sink_never_high_r3: assert property (@(posedge clk) disable iff (rst)
            (mode1[i] && !mode0[i]) |-> !pad_out[i]);
        p_src_never_low_r3: assert property (@(posedge clk) disable iff (rst)
            (mode1[i] && mode0[i] && pad_oe[i]) |-> pad_out[i]);
    end

endmodule

// File: rtl/keyed_gpio_ctrl.sv
module keyed_gpio_ctrl
    import kgc_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [11:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    localparam int unsigned PW = NUM_PINS;

    wr_sel_t       sel;
    logic          armed;
    logic [PW-1:0] dout, mode0, mode1, din_q;

    always_comb sel = decode_write(bus_wr, bus_addr);

    kgc_sync #(.WIDTH(PW), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in), .din_q(din_q)
    );

    kgc_lock u_lock (
        .clk(clk), .rst(rst), .lock_wr(sel.lock_wr),
        .key(bus_wdata[KEY_W-1:0]), .armed(armed)
    );

    kgc_regs #(.WIDTH(PW)) u_regs (
        .clk(clk), .rst(rst), .sel(sel), .wdata(bus_wdata[PW-1:0]),
        .armed(armed), .dout(dout), .mode0(mode0), .mode1(mode1)
    );

    kgc_pad #(.WIDTH(PW)) u_pad (
        .clk(clk), .rst(rst), .dout(dout), .mode0(mode0), .mode1(mode1),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [REG_W-1:0] widen(logic [PW-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        r[PW-1:0] = v;
        return r;
    endfunction

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_DIN:            bus_rdata = widen(din_q);
            OFS_MODE0:          bus_rdata = widen(mode0);
            OFS_MODE1:          bus_rdata = widen(mode1);
            OFS_DSET, OFS_DCLR: bus_rdata = widen(dout);
            OFS_LOCK:           bus_rdata[FLAG_BIT] = armed;
            default:            bus_rdata = '0;
        endcase
    end

    p_lock_readback_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_LOCK) |-> (bus_rdata[FLAG_BIT-1:0] == '0));

endmodule

// File: tb/keyed_gpio_ctrl_bench.sv
module keyed_gpio_ctrl_bench;
    localparam int PINS = 24;
    localparam bit [31:0] PMASK = (32'h1 << PINS) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr = 1'b0;
    logic [11:0]     bus_addr = 12'h000;
    logic [31:0]     bus_wdata = 32'h0;
    logic [31:0]     bus_rdata;
    logic [PINS-1:0] pad_in = '0;
    logic [PINS-1:0] pad_out, pad_oe;

    always #4 clk = ~clk;

    keyed_gpio_ctrl #(.NUM_PINS(PINS)) u_keyed_gpio_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Behavioural reference model
    bit [31:0] m_dout, m_m0, m_m1;
    bit        m_arm;
    bit [31:0] hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_dout = 0; m_m0 = 0; m_m1 = 0; m_arm = 0;
            hist.delete();
        end else begin
            if (bus_wr) begin
                bit [31:0] w;
                w = bus_wdata & PMASK;
                case (bus_addr)
                    12'h014: m_dout = m_dout | w;
                    12'h018: m_dout = m_dout & ~w;
                    12'h088: begin
                        if (bus_wdata[15:0] == 16'hD42F) m_arm = 1;
                        else if (bus_wdata[15:0] == 16'h0000) m_arm = 0;
                    end
                    default: ;
                endcase
                if (m_arm_prev_ok(bus_addr)) begin
                    case (bus_addr)
                        12'h054: m_m0 = m_m0 | w;
                        12'h058: m_m0 = m_m0 & ~w;
                        12'h00C: m_m0 = w;
                        12'h04C: m_m1 = m_m1 | w;
                        12'h050: m_m1 = m_m1 & ~w;
                        12'h008: m_m1 = w;
                        default: ;
                    endcase
                end
            end
            hist.push_back({8'h0, pad_in});
            if (hist.size() > 3) void'(hist.pop_front());
        end
    end

    // Mode writes use the lock state held before this edge; the lock
    // offset never coincides with a mode offset, so m_arm is still old here.
    function automatic bit m_arm_prev_ok(logic [11:0] a);
        return m_arm && (a != 12'h088);
    endfunction

    function automatic bit [31:0] exp_read(logic [11:0] a);
        case (a)
            12'h004: return (hist.size() == 3) ? hist[0] : 32'h0;
            12'h008: return m_m1;
            12'h00C: return m_m0;
            12'h014, 12'h018: return m_dout;
            12'h088: return {m_arm, 31'h0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic exp_pads(output bit [PINS-1:0] o, output bit [PINS-1:0] e);
        o = '0; e = '0;
        for (int i = 0; i < PINS; i++) begin
            case ({m_m1[i], m_m0[i]})
                2'b01: begin e[i] = 1; o[i] = m_dout[i]; end
                2'b10: begin e[i] = !m_dout[i]; o[i] = 0; end
                2'b11: begin e[i] = m_dout[i]; o[i] = m_dout[i]; end
                default: ;
            endcase
        end
    endtask

    task automatic chk(string req, bit [31:0] act, bit [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit [PINS-1:0] eo, ee;
            exp_pads(eo, ee);
            chk(cur_req, bus_rdata, exp_read(bus_addr));
            chk({cur_req, "/R3"}, {8'h0, pad_oe, pad_out[7:0]}, {8'h0, ee, eo[7:0]});
            chk({cur_req, "/R3"}, {8'h0, pad_out}, {8'h0, eo});
        end
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 0;
    endtask

    task automatic rd(logic [11:0] a, string req, bit [31:0] exp);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1 reset state
        cur_req = "R1";
        rd(12'h008, "R1", 0);
        rd(12'h00C, "R1", 0);
        rd(12'h014, "R1", 0);
        rd(12'h088, "R1", 0);
        chk("R1", {8'h0, pad_oe}, 0);

        // R2 data set / clear, R8 upper bits dropped
        cur_req = "R2";
        wr(12'h014, 32'hFFFF_FFFF);
        rd(12'h014, "R8", 32'h00FF_FFFF);
        wr(12'h018, 32'h0F0F_0F0F);
        rd(12'h018, "R2", 32'h00F0_F0F0);
        wr(12'h014, 32'h0000_0003);
        rd(12'h014, "R2", 32'h00F0_F0F3);

        // R5 mode writes ignored while disarmed
        cur_req = "R5";
        wr(12'h054, 32'hFFFF_FFFF);
        wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h00C, "R5", 0);
        rd(12'h008, "R5", 0);
        chk("R5", {8'h0, pad_oe}, 0);

        // R4 key handling
        cur_req = "R4";
        wr(12'h088, 32'h0000_1234);
        rd(12'h088, "R4", 0);
        wr(12'h054, 32'h1);
        rd(12'h00C, "R5", 0);
        wr(12'h088, 32'hFFFF_D42F);
        rd(12'h088, "R4", 32'h8000_0000);
        wr(12'h088, 32'h0000_5555);
        rd(12'h088, "R4", 32'h8000_0000);

        // R6 and R3 modes while armed
        cur_req = "R6";
        wr(12'h054, 32'h0000_00FF);
        wr(12'h04C, 32'h00FF_FF00);
        wr(12'h054, 32'hFFFF_0000);
        rd(12'h00C, "R6", 32'h00FF_00FF);
        rd(12'h008, "R6", 32'h00FF_FF00);
        cur_req = "R3";
        wr(12'h018, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R3", {8'h0, pad_oe}, 32'h0000_FFFF);
        chk("R3", {8'h0, pad_out}, 0);
        wr(12'h014, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R3", {8'h0, pad_oe}, 32'h00FF_00FF);
        chk("R3", {8'h0, pad_out}, 32'h00FF_00FF);
        wr(12'h018, 32'h00AA_AAAA);
        @(negedge clk);
        chk("R3", {8'h0, pad_oe}, 32'h0055_AAFF);
        chk("R3", {8'h0, pad_out}, 32'h0055_0055);

        cur_req = "R6";
        wr(12'h058, 32'h0000_000F);
        wr(12'h050, 32'h0000_0F00);
        rd(12'h00C, "R6", 32'h00FF_00F0);
        rd(12'h008, "R6", 32'h00FF_F000);
        wr(12'h00C, 32'hA5A5_A5A5);
        wr(12'h008, 32'h3C3C_3C3C);
        rd(12'h00C, "R6", 32'h00A5_A5A5);
        rd(12'h008, "R8", 32'h003C_3C3C);

        // R4 disarm then R5 ignored again
        cur_req = "R4";
        wr(12'h088, 32'h0);
        rd(12'h088, "R4", 0);
        cur_req = "R5";
        wr(12'h04C, 32'hFFFF_FFFF);
        wr(12'h058, 32'hFFFF_FFFF);
        rd(12'h008, "R5", 32'h003C_3C3C);
        rd(12'h00C, "R5", 32'h00A5_A5A5);

        // R7 synchronizer latency
        cur_req = "R7";
        bus_addr = 12'h004;
        repeat (4) @(posedge clk);
        #2 pad_in = 24'hC3_5A96;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R7", bus_rdata, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R7", bus_rdata, 32'h00C3_5A96);
        #2 pad_in = 24'h3C_A569;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7", bus_rdata, 32'h003C_A569);

        // R9 unmapped offsets
        cur_req = "R9";
        rd(12'h100, "R9", 0);
        rd(12'h054, "R9", 0);
        rd(12'h000, "R9", 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule